// File: doc/BRIEF.md
# Banked System Address Decoder

This block sits between a handheld console's 8-bit CPU and the targets of its 16-bit memory map. For every address it asserts one one-hot target select and gives a local offset into that target. The targets are fixed cartridge ROM, switchable cartridge ROM, video RAM, cartridge RAM, the two halves of working RAM, sprite attribute memory, I/O registers, high RAM and the interrupt-enable register. The memories, the I/O logic and the cartridge bank controller are all outside the block. The decoder only steers accesses to them.

Reads pass through the data that the selected target returns. When no target is selected, a read returns 0xFF. This covers the unusable hole below the I/O page and sprite memory while the video engine has it locked. The block decodes writes in the same way. A write into cartridge ROM space never reaches ROM: it is raised as a control write for the cartridge bank controller.

The block holds one piece of state, the working-RAM bank register. It lives at an I/O address that is set by a parameter. It picks which upper bank serves the banked half of working RAM and that half's mirror. The target selects and offsets are combinational. The bank register changes on the clock edge of a write.

Top module: `sys_addr_decode`

## Requirements
- R1: Addresses 0x0000–0x3FFF select fixed ROM (sel bit 0), and 0x4000–0x7FFF select switchable ROM (sel bit 1). In both cases the offset is addr[13:0].
- R2: A write (wr_en high) to any address below 0x8000 raises ctrl_wr and leaves mem_we low. Every other access leaves ctrl_wr low.
- R3: 0x8000–0x9FFF selects video RAM (sel bit 2) in every video mode, and 0xA000–0xBFFF selects cartridge RAM (sel bit 3). Both use offset addr[12:0].
- R4: 0xC000–0xCFFF and its mirror 0xE000–0xEFFF select working-RAM bank 0 (sel bit 4), with offset addr[11:0].
- R5: 0xD000–0xDFFF and its mirror 0xF000–0xFDFF select the banked working RAM (sel bit 5). The offset is {wram_bank, addr[11:0]}.
- R6: A write to 0xFF00+BANK_IO_OFS loads the low WBANK_W bits of wdata into the bank register on the clock edge. wram_bank shows the stored value, except that a stored 0 shows as 1. After reset wram_bank is 1. A write to any other address leaves it unchanged.
- R7: 0xFE00–0xFE9F selects sprite memory (sel bit 6) with offset addr[7:0] only while video_mode is 0 or 1. In modes 2 and 3 no target is selected, reads return 0xFF and mem_we stays low.
- R8: 0xFEA0–0xFEFF selects no target: sel is 0, offset is 0, rdata is 0xFF and mem_we stays low.
- R9: 0xFF00–0xFF7F selects I/O (sel bit 7, offset addr[6:0]). 0xFF80–0xFFFE selects high RAM (sel bit 8, offset addr[6:0]). 0xFFFF selects the interrupt-enable register (sel bit 9, offset 0).
- R10: rdata equals tgt_rdata whenever a target is selected, and 0xFF otherwise. mem_we equals wr_en when a target at or above 0x8000 is selected. At most one sel bit is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU byte address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 8 | Write data |
| video_mode | input | 2 | Current video engine mode (0..3) |
| tgt_rdata | input | 8 | Read data returned by the selected target |
| sel | output | 10 | One-hot target select |
| offset | output | WBANK_W+12 | Local offset inside the selected target |
| rdata | output | 8 | Read data to the CPU |
| mem_we | output | 1 | Write enable to the selected target |
| ctrl_wr | output | 1 | Control write to the cartridge bank controller |
| wram_bank | output | WBANK_W | Effective working-RAM upper bank |

## Verification
The bench builds the block with its default parameters: a 3-bit bank register at I/O offset 0x70, which gives a 15-bit offset. With this width every bank value can be reached with a single write. This includes the write of zero that is remapped to bank 1, and a wide value whose upper bits must be dropped. The table covers the edge addresses of every region, the mirrors and all four video modes over sprite memory. Directed writes then move the bank register and show the banked offset following it in both the main window and the mirror.

// File: rtl/sys_addr_decode.sv
module sys_addr_decode #(
  parameter int          WBANK_W     = 3,
  parameter logic [6:0]  BANK_IO_OFS = 7'h70,
  localparam int         NTGT        = 10,
  localparam int         OFS_W       = WBANK_W + 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        addr,
  input  logic               wr_en,
  input  logic [7:0]         wdata,
  input  logic [1:0]         video_mode,
  input  logic [7:0]         tgt_rdata,
  output logic [NTGT-1:0]    sel,
  output logic [OFS_W-1:0]   offset,
  output logic [7:0]         rdata,
  output logic               mem_we,
  output logic               ctrl_wr,
  output logic [WBANK_W-1:0] wram_bank
);
  localparam int T_ROM0 = 0, T_ROMX = 1, T_VRAM = 2, T_CRAM = 3, T_WRAM0 = 4;
  localparam int T_WRAMX = 5, T_OAM = 6, T_IO = 7, T_HRAM = 8, T_IE = 9;
  localparam logic [15:0] BANK_ADDR = {8'hFF, 1'b0, BANK_IO_OFS};

  logic [WBANK_W-1:0] bank_raw;
  logic               oam_open;
  logic               unused_bits;

  assign unused_bits = &{1'b0, wdata[7:WBANK_W], video_mode[0]};
  assign oam_open    = ~video_mode[1];
  assign wram_bank   = (bank_raw == '0) ? WBANK_W'(1) : bank_raw;

  always_ff @(posedge clk) begin
    if (!rst_n)
      bank_raw <= '0;
    else if (wr_en && addr == BANK_ADDR)
      bank_raw <= wdata[WBANK_W-1:0];
  end

  always_comb begin
    sel    = '0;
    offset = '0;
    case (addr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: begin
        sel[T_ROM0] = 1'b1;
        offset      = OFS_W'(addr[13:0]);
      end
      4'h4, 4'h5, 4'h6, 4'h7: begin
        sel[T_ROMX] = 1'b1;
        offset      = OFS_W'(addr[13:0]);
      end
      4'h8, 4'h9: begin
        sel[T_VRAM] = 1'b1;
        offset      = OFS_W'(addr[12:0]);
      end
      4'hA, 4'hB: begin
        sel[T_CRAM] = 1'b1;
        offset      = OFS_W'(addr[12:0]);
      end
      4'hC, 4'hE: begin
        sel[T_WRAM0] = 1'b1;
        offset       = OFS_W'(addr[11:0]);
      end
      4'hD: begin
        sel[T_WRAMX] = 1'b1;
        offset       = {wram_bank, addr[11:0]};
      end
      default: begin
        if (addr[11:9] != 3'b111) begin
          sel[T_WRAMX] = 1'b1;
          offset       = {wram_bank, addr[11:0]};
        end else if (addr[8] == 1'b0) begin
          if (addr[7:0] < 8'hA0 && oam_open) begin
            sel[T_OAM] = 1'b1;
            offset     = OFS_W'(addr[7:0]);
          end
        end else if (addr[7] == 1'b0) begin
          sel[T_IO] = 1'b1;
          offset    = OFS_W'(addr[6:0]);
        end else if (addr[6:0] == 7'h7F) begin
          sel[T_IE] = 1'b1;
        end else begin
          sel[T_HRAM] = 1'b1;
          offset      = OFS_W'(addr[6:0]);
        end
      end
    endcase
  end

  assign ctrl_wr = wr_en & ~addr[15];
  assign mem_we  = wr_en & addr[15] & (|sel);
  assign rdata   = (|sel) ? tgt_rdata : 8'hFF;
endmodule

// File: rtl/sys_addr_decode_chk.sv
module sys_addr_decode_chk #(
  parameter int          WBANK_W     = 3,
  parameter logic [6:0]  BANK_IO_OFS = 7'h70
) (
  input logic               clk,
  input logic               rst_n,
  input logic [15:0]        addr,
  input logic               wr_en,
  input logic [7:0]         wdata,
  input logic [1:0]         video_mode,
  input logic [9:0]         sel,
  input logic [7:0]         rdata,
  input logic               mem_we,
  input logic               ctrl_wr,
  input logic [WBANK_W-1:0] wram_bank
);
  localparam logic [15:0] BANK_ADDR = {8'hFF, 1'b0, BANK_IO_OFS};

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_ctrl_only_rom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |-> (wr_en && !addr[15] && !mem_we));

  assert_bank_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wram_bank != '0);

  assert_bank_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == BANK_ADDR) |=>
      wram_bank == (($past(wdata[WBANK_W-1:0]) == '0) ? WBANK_W'(1) : $past(wdata[WBANK_W-1:0])));

  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == BANK_ADDR) |=> $stable(wram_bank));

  assert_oam_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 16'hFE00 && addr < 16'hFEA0 && video_mode[1]) |-> (sel == '0 && rdata == 8'hFF && !mem_we));

  assert_hole_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 16'hFEA0 && addr < 16'hFF00) |-> (sel == '0 && rdata == 8'hFF && !mem_we));
endmodule

bind sys_addr_decode sys_addr_decode_chk #(.WBANK_W(WBANK_W), .BANK_IO_OFS(BANK_IO_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .video_mode(video_mode), .sel(sel), .rdata(rdata), .mem_we(mem_we),
  .ctrl_wr(ctrl_wr), .wram_bank(wram_bank)
);

// File: tb/sys_addr_decode_tb_top.sv
module sys_addr_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [1:0]  video_mode = '0;
  logic [7:0]  tgt_rdata = 8'h5A;
  logic [9:0]  sel;
  logic [14:0] offset;
  logic [7:0]  rdata;
  logic        mem_we, ctrl_wr;
  logic [2:0]  wram_bank;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sys_addr_decode dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .video_mode(video_mode), .tgt_rdata(tgt_rdata), .sel(sel), .offset(offset),
    .rdata(rdata), .mem_we(mem_we), .ctrl_wr(ctrl_wr), .wram_bank(wram_bank)
  );

  // {addr, video_mode, expected sel, expected offset}; bank register at reset value 1
  localparam int NV = 25;
  localparam logic [42:0] VEC [NV] = '{
    {16'h0000, 2'd0, 10'h001, 15'h0000},  // R1
    {16'h3FFF, 2'd0, 10'h001, 15'h3FFF},  // R1
    {16'h4000, 2'd0, 10'h002, 15'h0000},  // R1
    {16'h7ABC, 2'd0, 10'h002, 15'h3ABC},  // R1
    {16'h8000, 2'd0, 10'h004, 15'h0000},  // R3
    {16'h9FFF, 2'd3, 10'h004, 15'h1FFF},  // R3
    {16'hA123, 2'd2, 10'h008, 15'h0123},  // R3
    {16'hBFFF, 2'd0, 10'h008, 15'h1FFF},  // R3
    {16'hC010, 2'd0, 10'h010, 15'h0010},  // R4
    {16'hE010, 2'd0, 10'h010, 15'h0010},  // R4
    {16'hEFFF, 2'd0, 10'h010, 15'h0FFF},  // R4
    {16'hD123, 2'd0, 10'h020, 15'h1123},  // R5
    {16'hF123, 2'd0, 10'h020, 15'h1123},  // R5
    {16'hFDFF, 2'd0, 10'h020, 15'h1DFF},  // R5
    {16'hFE05, 2'd1, 10'h040, 15'h0005},  // R7
    {16'hFE9F, 2'd0, 10'h040, 15'h009F},  // R7
    {16'hFE10, 2'd2, 10'h000, 15'h0000},  // R7
    {16'hFE10, 2'd3, 10'h000, 15'h0000},  // R7
    {16'hFEA0, 2'd0, 10'h000, 15'h0000},  // R8
    {16'hFEFF, 2'd1, 10'h000, 15'h0000},  // R8
    {16'hFF00, 2'd0, 10'h080, 15'h0000},  // R9
    {16'hFF7F, 2'd0, 10'h080, 15'h007F},  // R9
    {16'hFF80, 2'd0, 10'h100, 15'h0000},  // R9
    {16'hFFFE, 2'd0, 10'h100, 15'h007E},  // R9
    {16'hFFFF, 2'd0, 10'h200, 15'h0000}   // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bank_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset bank", 32'(wram_bank), 32'd1);

    for (int i = 0; i < NV; i++) begin
      addr = VEC[i][42:27];
      video_mode = VEC[i][26:25];
      #1;
      chk($sformatf("R1-9 table sel @%h", VEC[i][42:27]), 32'(sel), 32'(VEC[i][24:15]));
      chk($sformatf("R1-9 table offset @%h", VEC[i][42:27]), 32'(offset), 32'(VEC[i][14:0]));
      chk($sformatf("R10 rdata @%h", VEC[i][42:27]), 32'(rdata),
          (VEC[i][24:15] != 0) ? 32'h5A : 32'hFF);
    end

    // R6: bank register loads and remaps
    bank_write(16'hFF70, 8'h05);
    chk("R6 bank=5", 32'(wram_bank), 32'd5);
    addr = 16'hD001; #1;
    chk("R5 banked offset", 32'(offset), 32'h5001);
    addr = 16'hF002; #1;
    chk("R5 mirror banked offset", 32'(offset), 32'h5002);
    bank_write(16'hFF71, 8'h03);
    chk("R6 other address ignored", 32'(wram_bank), 32'd5);
    bank_write(16'hFF70, 8'h00);
    chk("R6 zero remaps to 1", 32'(wram_bank), 32'd1);
    bank_write(16'hFF70, 8'hFA);
    chk("R6 low bits only", 32'(wram_bank), 32'd2);
    bank_write(16'hFF70, 8'h08);
    chk("R6 low bits zero remap", 32'(wram_bank), 32'd1);
    bank_write(16'hFF70, 8'h07);
    addr = 16'hDFFF; #1;
    chk("R5 top bank offset", 32'(offset), 32'h7FFF);

    // R2: cartridge control writes
    @(negedge clk);
    addr = 16'h2000; wdata = 8'h01; wr_en = 1'b1; #1;
    chk("R2 ctrl_wr rom write", 32'(ctrl_wr), 32'd1);
    chk("R2 no mem_we rom write", 32'(mem_we), 32'd0);
    addr = 16'h7FFF; #1;
    chk("R2 ctrl_wr top rom", 32'(ctrl_wr), 32'd1);
    addr = 16'hC000; #1;
    chk("R2 no ctrl_wr ram", 32'(ctrl_wr), 32'd0);
    chk("R10 mem_we wram", 32'(mem_we), 32'd1);
    addr = 16'h8000; #1;
    chk("R3 mem_we vram", 32'(mem_we), 32'd1);
    // R7: sprite memory write gating
    addr = 16'hFE10; video_mode = 2'd2; #1;
    chk("R7 oam write dropped", 32'(mem_we), 32'd0);
    video_mode = 2'd0; #1;
    chk("R7 oam write open", 32'(mem_we), 32'd1);
    // R8: hole write
    addr = 16'hFEA5; #1;
    chk("R8 hole write ignored", 32'(mem_we), 32'd0);
    addr = 16'hFF90; #1;
    chk("R9 hram write", 32'(mem_we), 32'd1);
    @(negedge clk);
    wr_en = 1'b0;
    addr = 16'h2000; #1;
    chk("R2 read no ctrl_wr", 32'(ctrl_wr), 32'd0);
    chk("R6 bank unchanged by other writes", 32'(wram_bank), 32'd7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule